// File: doc/BRIEF.md
# Power-of-Two Output Divider with Paced Slow-Down

This block derives an output clock from a fast VCO clock. A two-bit code picks one of four divide ratios, and the output keeps equal high and low times at every ratio. A power-down request lowers the output frequency by a further factor of sixteen. The block does not make that change in one jump. It applies the extra factor one doubling at a time, and a slow reference clock sets the pace. When the request is dropped, the output climbs back to the programmed rate in four equal steps.

A state machine in the reference domain holds a slow-down level from 0 to 4. The extra divide factor is two to the power of that level. The states are:
- ST_FULL: level 0, no extra division.
- ST_DESCEND: the level rises by one after each interval.
- ST_SLOW: level 4, divide by 16 more.
- ST_ASCEND: the level falls by one after each interval.

The transitions are:
- FULL to DESCEND when the synchronized request rises.
- DESCEND to SLOW when the level reaches 4.
- DESCEND to ASCEND when the request drops.
- SLOW to ASCEND when the request drops.
- ASCEND to FULL when the level reaches 0.
- ASCEND to DESCEND when the request returns.

The level is Gray-coded and crosses into the VCO domain through two flops. In the VCO domain, a free-running binary counter supplies the divided clock. Its bit at position (exponent − 1) is the output. A total exponent of 0 routes the VCO clock itself through a select that changes only while the VCO clock is low. A new exponent is adopted only at the end of a high phase, when the output is about to fall.

Top module: `postdiv_stepdown`

## Requirements
- R1: With the power-down request low, the output period is the VCO period times the programmed ratio. ratio_code 2'b00 selects 2, 2'b01 selects 4, 2'b10 selects 8, and 2'b11 selects 1.
- R2: At every ratio, the high and low phases of clk_out are equal in length.
- R3: While rst_n is low, clk_out is held low.
- R4: While pwr_dn is held high, the output ratio settles at the programmed ratio times 16.
- R5: After pwr_dn rises, the extra factor passes through 2, 4 and 8 in that order before reaching 16, and no level is skipped.
- R6: After pwr_dn falls, the output returns to the programmed rate in exactly four increments: extra factor 8, then 4, then 2, then 1.
- R7: The level moves by at most one step per STEP_CYCLES (default 8) reference clock cycles. A full climb from factor 16 to factor 1 therefore takes at least 4·STEP_CYCLES reference cycles.
- R8: A change of ratio takes effect only where a high phase ends. Every high or low phase equals either the old or the new ratio's half period, so no runt pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Fast clock to be divided |
| ref_clk | input | 1 | Slow clock that paces the power-down steps |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ratio_code | input | 2 | Programmed divide ratio code (see R1) |
| pwr_dn | input | 1 | Power-down request, synchronized internally |
| clk_out | output | 1 | Divided output clock |

## Verification
The hardest situation to reach is the handover between two ratios while the level is still moving. It is the only place where a short phase could appear or a step could be skipped, and it exists only for a few reference intervals. The stimulus holds pwr_dn long enough for the full descent, then releases it. Meanwhile a monitor times every edge of clk_out. Each distinct phase length is compared in order against a queue of the five expected half periods. Any odd phase length, missing level or extra level shows up as a mismatch or as a queue that is not empty. The climb time is also bounded against the reference-clock pacing.

// File: rtl/pdsd_pkg.sv
package pdsd_pkg;

    localparam int LVL_W        = 3;
    localparam int MAX_LVL      = 4;
    localparam int BASE_EXP_MAX = 3;
    localparam int EXP_MAX      = BASE_EXP_MAX + MAX_LVL;
    localparam int EXP_W        = $clog2(EXP_MAX + 1);

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [EXP_W-1:0] exp_t;

    typedef enum logic [1:0] {
        ST_FULL,
        ST_DESCEND,
        ST_SLOW,
        ST_ASCEND
    } step_state_e;

    function automatic lvl_t to_gray(lvl_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic lvl_t from_gray(lvl_t g);
        lvl_t b;
        b[LVL_W-1] = g[LVL_W-1];
        for (int i = LVL_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // log2 of the programmed ratio
    function automatic exp_t base_exp(logic [1:0] code);
        exp_t e;
        unique case (code)
            2'b00: e = exp_t'(1);
            2'b01: e = exp_t'(2);
            2'b10: e = exp_t'(3);
            2'b11: e = exp_t'(0);
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pdsd_step_fsm.sv
module pdsd_step_fsm
    import pdsd_pkg::*;
#(
    parameter int STEP_CYCLES = 8
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic pwr_dn,
    output lvl_t lvl_gray
);

    localparam int   TMR_W   = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam lvl_t LVL_TOP = lvl_t'(MAX_LVL);
    localparam lvl_t LVL_PRE = lvl_t'(MAX_LVL - 1);

    logic [1:0]       pd_meta;
    logic             pd_req;
    step_state_e      state_q, state_d;
    lvl_t             lvl_q;
    lvl_t             gray_q;
    logic [TMR_W-1:0] tmr_q;
    logic             step_due;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) pd_meta <= '0;
        else        pd_meta <= {pd_meta[0], pwr_dn};
    end
    assign pd_req   = pd_meta[1];
    assign step_due = (tmr_q == TMR_W'(STEP_CYCLES - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FULL: begin
                if (pd_req) state_d = ST_DESCEND;
            end
            ST_DESCEND: begin
                if (!pd_req)                          state_d = ST_ASCEND;
                else if (lvl_q == LVL_TOP)            state_d = ST_SLOW;
                else if (step_due && lvl_q == LVL_PRE) state_d = ST_SLOW;
            end
            ST_SLOW: begin
                if (!pd_req) state_d = ST_ASCEND;
            end
            ST_ASCEND: begin
                if (pd_req)                              state_d = ST_DESCEND;
                else if (lvl_q == '0)                    state_d = ST_FULL;
                else if (step_due && lvl_q == lvl_t'(1)) state_d = ST_FULL;
            end
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FULL;
        else        state_q <= state_d;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q  <= '0;
            lvl_q  <= '0;
            gray_q <= '0;
        end else begin
            if (state_d != state_q || state_q == ST_FULL || state_q == ST_SLOW || step_due)
                tmr_q <= '0;
            else
                tmr_q <= tmr_q + TMR_W'(1);
            if (state_q == ST_DESCEND && pd_req && step_due && lvl_q != LVL_TOP)
                lvl_q <= lvl_q + lvl_t'(1);
            else if (state_q == ST_ASCEND && !pd_req && step_due && lvl_q != '0)
                lvl_q <= lvl_q - lvl_t'(1);
            gray_q <= to_gray(lvl_q);
        end
    end
    assign lvl_gray = gray_q;

    // R4
    slow_lvl_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        state_q == ST_SLOW |-> lvl_q == LVL_TOP);
    // R6
    full_lvl_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        state_q == ST_FULL |-> lvl_q == '0);
    // R7
    step_pace_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        lvl_q != $past(lvl_q) |-> $past(tmr_q) == TMR_W'(STEP_CYCLES - 1));

endmodule

// File: rtl/pdsd_gray_sync.sv
module pdsd_gray_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q, hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end
    assign q = hold_q;

endmodule

// File: rtl/pdsd_pow2_div.sv
module pdsd_pow2_div
    import pdsd_pkg::*;
(
    input  logic       vco_clk,
    input  logic       rst_n,
    input  logic [1:0] ratio_code,
    input  lvl_t       lvl_gray_s,
    output logic       clk_out
);

    localparam int CNT_W = EXP_MAX;

    lvl_t             lvl_bin;
    exp_t             e_tgt, e_act;
    logic [CNT_W-1:0] cnt_q, mask;
    logic             phase_end, swap, div_bit, sel_bp;

    assign lvl_bin   = from_gray(lvl_gray_s);
    assign e_tgt     = base_exp(ratio_code) + exp_t'(lvl_bin);
    assign mask      = (CNT_W'(1) << e_act) - CNT_W'(1);
    assign phase_end = ((cnt_q & mask) == mask);
    assign swap      = (e_tgt != e_act) && phase_end;

    always_comb begin
        div_bit = 1'b0;
        for (int i = 1; i <= EXP_MAX; i++) begin
            if (e_act == exp_t'(i)) div_bit = cnt_q[i-1];
        end
    end

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) begin
            e_act <= '0;
            cnt_q <= '0;
        end else if (swap) begin
            e_act <= e_tgt;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // bypass select moves only while the VCO clock is low
    always_ff @(negedge vco_clk or negedge rst_n) begin
        if (!rst_n) sel_bp <= 1'b0;
        else        sel_bp <= (e_act == '0);
    end

    assign clk_out = sel_bp ? vco_clk : div_bit;

    // R8
    exp_switch_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
        ($past(e_act) != '0 && e_act != $past(e_act)) |-> $past(div_bit));
    // R5
    gray_one_bit_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
        $countones(lvl_gray_s ^ $past(lvl_gray_s)) <= 1);

endmodule

// File: rtl/postdiv_stepdown.sv
module postdiv_stepdown
    import pdsd_pkg::*;
#(
    parameter int STEP_CYCLES = 8
) (
    input  logic       vco_clk,
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic [1:0] ratio_code,
    input  logic       pwr_dn,
    output logic       clk_out
);

    lvl_t lvl_gray_ref;
    lvl_t lvl_gray_vco;

    pdsd_step_fsm #(.STEP_CYCLES(STEP_CYCLES)) u_step (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .lvl_gray (lvl_gray_ref)
    );

    pdsd_gray_sync #(.W(LVL_W)) u_sync (
        .clk   (vco_clk),
        .rst_n (rst_n),
        .d     (lvl_gray_ref),
        .q     (lvl_gray_vco)
    );

    pdsd_pow2_div u_div (
        .vco_clk    (vco_clk),
        .rst_n      (rst_n),
        .ratio_code (ratio_code),
        .lvl_gray_s (lvl_gray_vco),
        .clk_out    (clk_out)
    );

endmodule

// File: tb/postdiv_stepdown_tb_top.sv
`timescale 1ns/1ps
module postdiv_stepdown_tb_top;

    logic       vco_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [1:0] ratio_code = 2'b00;
    logic       pwr_dn  = 1'b0;
    logic       clk_out;

    int n_chk  = 0;
    int n_fail = 0;

    int    exp_q[$];
    bit    mon_on = 1'b0;
    int    prev_w = -1;
    int    hi_w = 0, lo_w = 0;
    realtime last_t = 0.0, last_pop_t = 0.0;
    string cur_req = "R1";

    always #4 vco_clk = ~vco_clk;
    initial begin
        #37;
        forever #100 ref_clk = ~ref_clk;
    end

    postdiv_stepdown dut_i (
        .vco_clk    (vco_clk),
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .ratio_code (ratio_code),
        .pwr_dn     (pwr_dn),
        .clk_out    (clk_out)
    );

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // monitor: time every phase, compare each new phase length with the queue
    always @(clk_out) begin
        realtime t;
        int w;
        t = $realtime;
        w = $rtoi(t - last_t + 0.5);
        last_t = t;
        if (clk_out == 1'b0) hi_w = w;
        else                 lo_w = w;
        if (mon_on && w != prev_w) begin
            prev_w = w;
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, w, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(w == e, cur_req, w, e);
                last_pop_t = t;
            end
        end
    end

    task automatic restart(logic [1:0] code);
        @(posedge vco_clk); #2;
        rst_n = 1'b0;
        pwr_dn = 1'b0;
        ratio_code = code;
        #300;
        // R3: output held low while in reset
        for (int k = 0; k < 3; k++) begin
            #13;
            check(clk_out == 1'b0, "R3", int'(clk_out), 0);
        end
        @(posedge vco_clk); #2;
        rst_n = 1'b1;
        #2000;
    endtask

    task automatic run_steady(logic [1:0] code, int half);
        restart(code);
        cur_req = "R1";
        prev_w = -1;
        exp_q.push_back(half);
        mon_on = 1'b1;
        #3000;
        mon_on = 1'b0;
        check(exp_q.size() == 0, "R1", exp_q.size(), 0);
        check(hi_w == half && lo_w == half, "R2", hi_w, lo_w);
    endtask

    task automatic run_power(logic [1:0] code, int b);
        realtime t0;
        restart(code);
        cur_req = "R5";
        prev_w = -1;
        for (int k = 0; k <= 4; k++) exp_q.push_back(b << k);
        mon_on = 1'b1;
        #100;
        pwr_dn = 1'b1;
        #9000;
        check(exp_q.size() == 0, "R5", exp_q.size(), 0);
        check(prev_w == 16 * b, "R4", prev_w, 16 * b);
        cur_req = "R6";
        for (int k = 3; k >= 0; k--) exp_q.push_back(b << k);
        @(posedge vco_clk); #2;
        t0 = $realtime;
        pwr_dn = 1'b0;
        #9000;
        mon_on = 1'b0;
        check(exp_q.size() == 0, "R6", exp_q.size(), 0);
        check(prev_w == b, "R6", prev_w, b);
        // R7: climb paced by 4 x 8 reference cycles of 200 ns
        check((last_pop_t - t0) >= 6400.0 && (last_pop_t - t0) <= 7800.0, "R7",
              $rtoi(last_pop_t - t0), 6400);
    endtask

    initial begin
        // R1, R2 at each code; half period = ratio x 4 ns
        run_steady(2'b00, 8);
        run_steady(2'b01, 16);
        run_steady(2'b10, 32);
        run_steady(2'b11, 4);
        // R4..R8: stepped slow-down and climb
        run_power(2'b01, 16);
        run_power(2'b00, 8);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule